// File: doc/BRIEF.md
# Banked Register Pointer with Coherent Time Snapshot

This block keeps the byte address pointer of a serial-bus register slave that exposes three banks. Bank 0 holds thirteen live timekeeping registers. Banks 1 and 2 are 256-byte nonvolatile data areas. The bank is chosen by two bank bits taken from the slave address byte. The first data byte of a write loads the pointer, and every byte moved after that advances it. How the pointer wraps depends on the bank and on the direction of the transfer.

Reads from bank 0 are not served from the counting registers. They come from a shadow copy. The shadow is refreshed from the live time values on every bus START and each time the bank-0 pointer rolls over to 00h. A multibyte read therefore returns one consistent instant while the clock keeps running. Writes to bank 0 go straight to the primary registers through a write enable. Data-bank writes leave through a separate enable, and the nonvolatile array sits outside this block.

Top module: `regptr_ctrl`

## Requirements
- R1: A cycle with `addr_valid` high and `bank_sel` equal to 0, 1 or 2 loads that bank. The value 3 is ignored. The bank is held at all other times. `eff_addr[9:8]` shows the bank and `eff_addr[7:0]` shows the pointer.
- R2: In bank 0, each read or write strobe advances the pointer by one. When the pointer is at 0Ch or at any higher value, the strobe returns it to 00h.
- R3: A `bus_start` pulse copies `live_time` into the shadow registers, and the copy is visible from the next cycle. Live register i sits in bits `8*i+7 : 8*i`.
- R4: When a bank-0 strobe rolls the pointer over to 00h, the shadow takes the `live_time` value present in that same cycle.
- R5: In bank 0, with the pointer below 13, `rd_data` equals the shadow byte at the pointer. Otherwise `rd_data` is zero. The shadow changes only under R3 or R4, whatever `live_time` does.
- R6: In banks 1 and 2, a read strobe advances the pointer by one and goes from FFh to 00h. The bank does not change.
- R7: In banks 1 and 2, a write strobe advances only pointer bits [2:0], wrapping inside the current 8-byte page. Bits [7:3] are kept.
- R8: `ptr_load` sets the pointer to `ptr_data` on the next edge. In the same cycle it overrides any read or write strobe and any wrap snapshot.
- R9: `time_we` is high only when `wr_strobe` is high, `ptr_load` is low, the bank is 0 and the pointer is below 13. `nv_we` is high only when `wr_strobe` is high, `ptr_load` is low and the bank is 1 or 2.
- R10: After reset, the bank is 0, the pointer is 0, every shadow byte is 0 and both enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Single-cycle pulse marking a bus START |
| addr_valid | input | 1 | Address byte received; `bank_sel` is valid |
| bank_sel | input | 2 | Bank bits from the slave address byte |
| ptr_load | input | 1 | First data byte of a write: load the pointer |
| ptr_data | input | 8 | Value to load into the pointer |
| rd_strobe | input | 1 | A read data byte was transferred |
| wr_strobe | input | 1 | A write data byte was transferred |
| live_time | input | 104 | Live time registers, byte i at bits 8*i+7:8*i |
| eff_addr | output | 10 | Bank and pointer `{bank, ptr}` |
| rd_data | output | 8 | Shadow byte at the pointer (bank 0) or zero |
| time_we | output | 1 | Write enable for primary time register `eff_addr[3:0]` |
| nv_we | output | 1 | Write enable for data-bank byte `eff_addr` |

## Verification
The bench runs a bank-0 read through two full wraps while `live_time` changes every cycle. A shadow that follows the live values, or one that misses the wrap refresh, returns wrong bytes after 0Ch. A data-bank write is tried from every one of the 256 start addresses, which catches a page wrap that carries into bit 3 or a write that wraps at FFh like a read. The bench also covers a read that crosses FFh, a pointer loaded above 0Ch in bank 0, and a load that arrives together with a strobe. Each of these exposes a design that increments when it should load, or that raises `time_we` for an address that does not exist.

// File: rtl/regptr_pkg.sv
package regptr_pkg;
    localparam int PTR_W  = 8;
    localparam int BANK_W = 2;

    localparam logic [BANK_W-1:0] BANK_TIME = 2'd0;
    localparam logic [BANK_W-1:0] BANK_NV_A = 2'd1;
    localparam logic [BANK_W-1:0] BANK_NV_B = 2'd2;
    localparam logic [BANK_W-1:0] BANK_RSVD = 2'd3;

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [BANK_W-1:0] bank_t;

    typedef struct packed {
        bank_t bank;
        ptr_t  ptr;
    } ptr_state_t;
endpackage

// File: rtl/regptr_step.sv
module regptr_step
    import regptr_pkg::*;
#(
    parameter int TIME_REGS = 13,
    parameter int PAGE_BITS = 3
) (
    input  bank_t bank,
    input  ptr_t  ptr,
    input  logic  is_write,
    output ptr_t  ptr_next,
    output logic  time_wrap
);
    localparam ptr_t LAST_TIME = ptr_t'(TIME_REGS - 1);

    logic [PAGE_BITS-1:0] page_off;

    always_comb begin
        page_off  = ptr[PAGE_BITS-1:0] + 1'b1;
        time_wrap = 1'b0;
        ptr_next  = ptr + 1'b1;
        if (bank == BANK_TIME) begin
            if (ptr >= LAST_TIME) begin
                ptr_next  = '0;
                time_wrap = 1'b1;
            end
        end else if (is_write) begin
            ptr_next = {ptr[PTR_W-1:PAGE_BITS], page_off};
        end
    end
endmodule

// File: rtl/regptr_shadow.sv
module regptr_shadow
    import regptr_pkg::*;
#(
    parameter int TIME_REGS = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   snap,
    input  logic [8*TIME_REGS-1:0] live_flat,
    input  ptr_t                   rd_idx,
    input  logic                   rd_en,
    output logic [7:0]             rd_data
);
    localparam int IDX_W = $clog2(TIME_REGS);

    logic [TIME_REGS-1:0][7:0] sh_d, sh_q;
    logic [IDX_W-1:0]          idx;

    always_comb begin
        sh_d = sh_q;
        if (snap) sh_d = live_flat;
        idx     = rd_idx[IDX_W-1:0];
        rd_data = 8'h00;
        if (rd_en && (rd_idx < ptr_t'(TIME_REGS))) rd_data = sh_q[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (sh_q == $past(live_flat))); // R3
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(sh_q)); // R5
endmodule

// File: rtl/regptr_ctrl.sv
module regptr_ctrl
    import regptr_pkg::*;
#(
    parameter int TIME_REGS = 13,
    parameter int PAGE_BITS = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_start,
    input  logic                   addr_valid,
    input  logic [1:0]             bank_sel,
    input  logic                   ptr_load,
    input  logic [7:0]             ptr_data,
    input  logic                   rd_strobe,
    input  logic                   wr_strobe,
    input  logic [8*TIME_REGS-1:0] live_time,
    output logic [9:0]             eff_addr,
    output logic [7:0]             rd_data,
    output logic                   time_we,
    output logic                   nv_we
);
    ptr_state_t st_d, st_q;
    ptr_t       step_ptr;
    logic       step_wrap;
    logic       advance;
    logic       snap;

    regptr_step #(.TIME_REGS(TIME_REGS), .PAGE_BITS(PAGE_BITS)) u_step (
        .bank      (st_q.bank),
        .ptr       (st_q.ptr),
        .is_write  (wr_strobe),
        .ptr_next  (step_ptr),
        .time_wrap (step_wrap)
    );

    always_comb begin
        st_d    = st_q;
        advance = !ptr_load && (rd_strobe || wr_strobe);
        if (addr_valid && bank_sel != BANK_RSVD) st_d.bank = bank_sel;
        if (ptr_load)     st_d.ptr = ptr_data;
        else if (advance) st_d.ptr = step_ptr;
        snap    = bus_start || (advance && step_wrap);
        time_we = wr_strobe && !ptr_load && st_q.bank == BANK_TIME
                  && st_q.ptr < ptr_t'(TIME_REGS);
        nv_we   = wr_strobe && !ptr_load
                  && (st_q.bank == BANK_NV_A || st_q.bank == BANK_NV_B);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    regptr_shadow #(.TIME_REGS(TIME_REGS)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap      (snap),
        .live_flat (live_time),
        .rd_idx    (st_q.ptr),
        .rd_en     (st_q.bank == BANK_TIME),
        .rd_data   (rd_data)
    );

    assign eff_addr = {st_q.bank, st_q.ptr};

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> $stable(eff_addr[9:8])); // R1
    AST_TIME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_addr[9:8] == 2'd0 && eff_addr[7:0] == 8'(TIME_REGS - 1)
         && (rd_strobe || wr_strobe) && !ptr_load) |=> eff_addr[7:0] == 8'h00); // R2
    AST_READ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_addr[9:8] != 2'd0 && eff_addr[7:0] == 8'hFF && rd_strobe
         && !wr_strobe && !ptr_load) |=> eff_addr[7:0] == 8'h00); // R6
    AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_addr[9:8] != 2'd0 && wr_strobe && !ptr_load)
        |=> eff_addr[7:PAGE_BITS] == $past(eff_addr[7:PAGE_BITS])); // R7
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |=> eff_addr[7:0] == $past(ptr_data)); // R8
    AST_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(time_we && nv_we)); // R9
endmodule

// File: tb/test_regptr_ctrl.sv
module test_regptr_ctrl;
    localparam int NREG = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_start = 1'b0, addr_valid = 1'b0, ptr_load = 1'b0;
    logic              rd_strobe = 1'b0, wr_strobe = 1'b0;
    logic [1:0]        bank_sel = 2'd0;
    logic [7:0]        ptr_data = 8'd0;
    logic [8*NREG-1:0] live_time = '0;
    logic [9:0]        eff_addr;
    logic [7:0]        rd_data;
    logic              time_we, nv_we;

    int checks = 0, errors = 0;
    logic [7:0] m_ptr = 8'd0;
    logic [1:0] m_bank = 2'd0;
    logic [7:0] m_sh [NREG];
    logic [7:0] m_live [NREG];

    always #2 clk = ~clk;

    regptr_ctrl i_regptr_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .addr_valid(addr_valid),
        .bank_sel(bank_sel), .ptr_load(ptr_load), .ptr_data(ptr_data),
        .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .live_time(live_time),
        .eff_addr(eff_addr), .rd_data(rd_data), .time_we(time_we), .nv_we(nv_we)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic set_live(input int k);
        for (int i = 0; i < NREG; i++) begin
            m_live[i] = 8'((i * 17 + k * 5 + 3) & 255);
            live_time[8*i +: 8] = m_live[i];
        end
    endtask

    function automatic logic [7:0] exp_rd();
        if (m_bank == 2'd0 && m_ptr < 8'd13) return m_sh[m_ptr[3:0]];
        return 8'h00;
    endfunction

    task automatic check_state(input string req);
        check({req, " eff_addr"}, 32'(eff_addr), 32'({m_bank, m_ptr}));
        check("R5 rd_data", 32'(rd_data), 32'(exp_rd()));
    endtask

    task automatic do_bank(input logic [1:0] b);
        addr_valid = 1'b1; bank_sel = b;
        tick;
        addr_valid = 1'b0;
        if (b != 2'd3) m_bank = b;
    endtask

    task automatic do_load(input logic [7:0] p);
        ptr_load = 1'b1; ptr_data = p;
        tick;
        ptr_load = 1'b0;
        m_ptr = p;
    endtask

    task automatic do_start;
        bus_start = 1'b1;
        for (int i = 0; i < NREG; i++) m_sh[i] = m_live[i];
        tick;
        bus_start = 1'b0;
    endtask

    task automatic do_byte(input logic wr);
        if (wr) wr_strobe = 1'b1; else rd_strobe = 1'b1;
        #1;
        check("R9 time_we", 32'(time_we), 32'(wr && m_bank == 2'd0 && m_ptr < 8'd13));
        check("R9 nv_we", 32'(nv_we), 32'(wr && m_bank != 2'd0));
        @(posedge clk);
        #1;
        wr_strobe = 1'b0; rd_strobe = 1'b0;
        if (m_bank == 2'd0) begin
            if (m_ptr >= 8'd12) begin
                m_ptr = 8'd0;
                for (int i = 0; i < NREG; i++) m_sh[i] = m_live[i]; // R4
            end else m_ptr = m_ptr + 8'd1;
        end else if (wr) m_ptr = {m_ptr[7:3], m_ptr[2:0] + 3'd1};
        else m_ptr = m_ptr + 8'd1;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin m_sh[i] = 8'd0; m_live[i] = 8'd0; end
        set_live(1);
        #7 rst_n = 1'b1;
        tick;
        // R10 reset state
        check("R10 eff_addr", 32'(eff_addr), 32'h0);
        check("R10 rd_data", 32'(rd_data), 32'h0);
        check("R10 time_we", 32'(time_we), 32'h0);
        check("R10 nv_we", 32'(nv_we), 32'h0);

        // R1 bank select sweep including reserved code
        for (int b = 0; b < 4; b++) begin
            do_bank(2'(b));
            check_state("R1");
        end
        do_bank(2'd0);

        // R3 snapshot on START, R5 shadow ignores live changes
        set_live(2);
        do_start;
        set_live(3);
        tick;
        for (int p = 0; p < NREG; p++) begin
            do_load(8'(p));
            check_state("R3");
        end

        // R2/R4 two wraps through bank 0 with live changing each byte
        do_load(8'd0);
        for (int n = 0; n < 28; n++) begin
            set_live(10 + n);
            do_byte(1'b0);
            check_state("R2 R4");
        end

        // R2/R9 pointer above 0Ch in bank 0
        do_load(8'h20);
        check_state("R2");
        do_byte(1'b1);
        check_state("R2");
        do_load(8'd10);
        for (int n = 0; n < 4; n++) begin
            do_byte(1'b1);
            check_state("R9");
        end

        // R6 data reads across FFh in both data banks
        for (int b = 1; b < 3; b++) begin
            do_bank(2'(b));
            do_load(8'hFC);
            for (int n = 0; n < 6; n++) begin
                do_byte(1'b0);
                check_state("R6");
            end
        end

        // R7 page wrap from every start address
        do_bank(2'd2);
        for (int p = 0; p < 256; p++) begin
            do_load(8'(p));
            do_byte(1'b1);
            check_state("R7");
        end

        // R8 load overrides strobe and wrap snapshot
        do_bank(2'd0);
        do_load(8'd12);
        set_live(77);
        ptr_load = 1'b1; ptr_data = 8'd5; rd_strobe = 1'b1; wr_strobe = 1'b1;
        #1;
        check("R8 time_we", 32'(time_we), 32'h0);
        check("R8 nv_we", 32'(nv_we), 32'h0);
        tick;
        ptr_load = 1'b0; rd_strobe = 1'b0; wr_strobe = 1'b0;
        m_ptr = 8'd5;
        check_state("R8");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule